// File: doc/BRIEF.md
# 66-to-32-bit Transmit Gearbox

This block sits between a 64b/66b encoder and a serial transceiver that takes one 32-bit word on every clock. Each input block is 66 bits wide: a 2-bit sync header and 64 scrambled payload bits. The output runs at a fixed rate of 32 bits per clock. The gearbox repacks the blocks into that word stream, with no bits lost and no bits added.

The whole block runs in one clock domain at the output word rate. A block carries 66 bits but takes only two output words' worth of time, so the gearbox absorbs the difference by holding off its source. The source sees a plain valid/ready handshake. A scheduler tracks how many bits are waiting in a shift buffer and raises `in_ready` only when the buffer would otherwise run short of a full word. For every 16 blocks accepted, 33 words leave the block, and the ready pattern repeats with that period. The extra cycle in each period is the one that carries the 32 accumulated header bits. After reset the buffer is empty and the pattern phase is zero.

Top module: `gbx_tx_66to32`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is low and `in_ready` is high. `out_valid` stays low until a block has been accepted. A reset in mid-stream discards every buffered bit.
- R2: The output carries the blocks in this serial order: header bit 0, header bit 1, payload bits 0 to 63, then the next block. Bit 0 of `out_word` carries the earliest bit of each word, and consecutive words continue the sequence with no gap.
- R3: The number of buffered bits never exceeds 97, which is one word less one bit plus one block.
- R4: `in_ready` is high in a cycle exactly when fewer than 32 bits remain after the current output word (if any) is removed.
- R5: `out_valid` is high exactly when at least 32 bits are buffered. A block accepted in one cycle makes `out_valid` high in the next. A source that is always valid gets an unbroken output from the cycle after its first block.
- R6: Take a source that is always valid, and count cycles from its first acceptance. `in_ready` then repeats with period 33: it is high at offsets 0, 2, ..., 30 and low at the odd offsets and at offset 32. The cycle after an acceptance never has `in_ready` high.
- R7: A block offered while `in_ready` is low is not taken and has no effect on the output stream. Only handshake cycles add data.
- R8: When no block arrives, `out_valid` drops once fewer than 32 bits are buffered. The leftover bits are kept and lead the output when blocks resume.
- R9: After every 33rd word emitted since reset, the buffer holds no leftover bits. If the source then offers nothing, `out_valid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source offers a block |
| in_ready | output | 1 | Gearbox takes the offered block this cycle |
| in_hdr | input | HDR_W (2) | Sync header of the offered block |
| in_payload | input | PAY_W (64) | Scrambled payload of the offered block |
| out_valid | output | 1 | `out_word` holds a full word |
| out_word | output | OUT_W (32) | Output word, earliest bit in bit 0 |

## Verification
The checker assumes a synchronous reset that is held across at least one rising edge. It also assumes that `in_valid` carries a defined value on every edge outside reset, because `accept` enters both the occupancy and the continuity properties. It places no holding rule on the source, since the gearbox samples the payload only on a handshake cycle. The stimulus therefore keeps `in_valid` low during reset and drives it from negative edges. In the R7 phase it changes the offered data on purpose while `in_ready` is low, to show that stalled offers leave no trace in the output.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

  // Greatest common divisor, evaluated at elaboration for the ratio pattern.
  function automatic int gcd_f(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = y;
      y = x % y;
      x = t;
    end
    return x;
  endfunction

  // Output words in one repeat of the rate pattern: lcm(blk, out) / out.
  function automatic int pattern_words(input int blk_w, input int out_w);
    return blk_w / gcd_f(blk_w, out_w);
  endfunction

  // Blocks consumed in one repeat of the rate pattern: lcm(blk, out) / blk.
  function automatic int pattern_blocks(input int blk_w, input int out_w);
    return out_w / gcd_f(blk_w, out_w);
  endfunction

  // Buffer depth: up to one word less a bit stays behind, then a block lands.
  function automatic int buffer_bits(input int blk_w, input int out_w);
    return blk_w + out_w - 1;
  endfunction

endpackage

// File: rtl/gbx_sched.sv
module gbx_sched #(
  parameter int BLK_W = 66,
  parameter int OUT_W = 32,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             emit,
  output logic             accept,
  output logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] rem
);

  localparam logic [CNT_W-1:0] WORD_BITS  = CNT_W'(OUT_W);
  localparam logic [CNT_W-1:0] BLOCK_BITS = CNT_W'(BLK_W);

  logic [CNT_W-1:0] fill_q;

  // Bits still buffered once this cycle's word (if any) has left.
  function automatic logic [CNT_W-1:0] after_emit(input logic [CNT_W-1:0] f,
                                                  input logic e);
    return e ? (f - WORD_BITS) : f;
  endfunction

  always_comb begin
    emit     = (fill_q >= WORD_BITS);
    rem      = after_emit(fill_q, emit);
    in_ready = (rem < WORD_BITS);
    accept   = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else begin
      fill_q <= rem + (accept ? BLOCK_BITS : '0);
    end
  end

  assign fill = fill_q;

endmodule

// File: rtl/gbx_buffer.sv
module gbx_buffer #(
  parameter int BLK_W = 66,
  parameter int OUT_W = 32,
  parameter int BUF_W = 97,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             emit,
  input  logic             accept,
  input  logic [CNT_W-1:0] wr_pos,
  input  logic [BLK_W-1:0] blk,
  output logic [OUT_W-1:0] word
);

  logic [BUF_W-1:0] buf_q;
  logic [BUF_W-1:0] kept;
  logic [BUF_W-1:0] landed;

  // Unused bits above the fill level stay zero, so a new block is OR-ed in.
  function automatic logic [BUF_W-1:0] place(input logic [BLK_W-1:0] b,
                                             input logic [CNT_W-1:0] pos);
    logic [BUF_W-1:0] ext;
    ext = {{(BUF_W-BLK_W){1'b0}}, b};
    return ext << pos;
  endfunction

  always_comb begin
    kept   = emit ? (buf_q >> OUT_W) : buf_q;
    landed = accept ? place(blk, wr_pos) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
    end else begin
      buf_q <= kept | landed;
    end
  end

  assign word = buf_q[OUT_W-1:0];

endmodule

// File: rtl/gbx_pattern.sv
module gbx_pattern #(
  parameter int WORDS = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic emit,
  output logic pat_wrap
);

  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  logic [IDX_W-1:0] idx_q;

  assign pat_wrap = emit && (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (emit) begin
      idx_q <= pat_wrap ? '0 : idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/gbx_tx_66to32.sv
module gbx_tx_66to32 #(
  parameter int HDR_W = 2,
  parameter int PAY_W = 64,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [HDR_W-1:0] in_hdr,
  input  logic [PAY_W-1:0] in_payload,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word
);

  localparam int BLK_W     = HDR_W + PAY_W;
  localparam int BUF_W     = gbx_pkg::buffer_bits(BLK_W, OUT_W);
  localparam int CNT_W     = $clog2(BUF_W + 1);
  localparam int PAT_WORDS = gbx_pkg::pattern_words(BLK_W, OUT_W);

  // Named internal events, observed by the bound checker.
  logic             emit_w;
  logic             accept_w;
  logic             pat_wrap_w;
  logic [CNT_W-1:0] fill_w;
  logic [CNT_W-1:0] rem_w;
  logic [BLK_W-1:0] blk_w;

  // Header occupies the low bits so it leaves first.
  assign blk_w = {in_payload, in_hdr};

  gbx_sched #(.BLK_W(BLK_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_sched (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .emit     (emit_w),
    .accept   (accept_w),
    .fill     (fill_w),
    .rem      (rem_w)
  );

  gbx_buffer #(.BLK_W(BLK_W), .OUT_W(OUT_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_buffer (
    .clk    (clk),
    .rst    (rst),
    .emit   (emit_w),
    .accept (accept_w),
    .wr_pos (rem_w),
    .blk    (blk_w),
    .word   (out_word)
  );

  gbx_pattern #(.WORDS(PAT_WORDS)) u_pattern (
    .clk      (clk),
    .rst      (rst),
    .emit     (emit_w),
    .pat_wrap (pat_wrap_w)
  );

  assign out_valid = emit_w;

endmodule

// File: rtl/gbx_checker.sv
module gbx_checker #(
  parameter int OUT_W = 32,
  parameter int BUF_W = 97,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             accept,
  input logic             pat_wrap,
  input logic [CNT_W-1:0] fill,
  input logic [CNT_W-1:0] rem
);

  localparam logic [CNT_W-1:0] WORD_BITS = CNT_W'(OUT_W);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    int'(fill) <= BUF_W);

  p_fed_continuous_r5: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  p_take_then_stall_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  p_stalled_drains_r7: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> (fill == $past(fill) - WORD_BITS));

  p_starved_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !accept) |=> $stable(fill));

  p_pattern_empty_r9: assert property (@(posedge clk) disable iff (rst)
    pat_wrap |-> (rem == '0));

endmodule

bind gbx_tx_66to32 gbx_checker #(.OUT_W(OUT_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_gbx_checker (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .accept    (accept_w),
  .pat_wrap  (pat_wrap_w),
  .fill      (fill_w),
  .rem       (rem_w)
);

// File: tb/test_gbx_tx_66to32.sv
`timescale 1ns/1ps
module test_gbx_tx_66to32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_hdr = '0;
  logic [63:0] in_payload = '0;
  logic        out_valid;
  logic [31:0] out_word;

  always #2 clk = ~clk;

  gbx_tx_66to32 i_gbx_tx_66to32 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_payload(in_payload),
    .out_valid(out_valid), .out_word(out_word)
  );

  // Stimulus blocks, and the expected ready pattern over one 33-cycle period.
  localparam logic [1:0] VH [16] = '{2'b01, 2'b10, 2'b10, 2'b01, 2'b10, 2'b01, 2'b01, 2'b10,
                                     2'b10, 2'b10, 2'b01, 2'b10, 2'b01, 2'b10, 2'b01, 2'b01};
  localparam logic [63:0] VD [16] = '{
    64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'hA5A5_5A5A_C3C3_3C3C,
    64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFE, 64'hDEAD_BEEF_CAFE_F00D, 64'h1357_9BDF_0246_8ACE,
    64'hF0F0_0F0F_FF00_00FF, 64'h5555_AAAA_3333_CCCC, 64'h0001_0002_0004_0008, 64'h9E37_79B9_7F4A_7C15,
    64'hE000_0000_0000_0007, 64'h2468_ACE0_1357_9BDF, 64'hC0DE_C0DE_C0DE_C0DE, 64'h0F1E_2D3C_4B5A_6978};
  localparam logic [32:0] EXP_READY = 33'h0_5555_5555;

  int n_chk = 0;
  int n_fail = 0;
  int head = 0;
  int tail = 0;
  int words = 0;
  bit done = 1'b0;
  bit refq [0:8191];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_blk(input logic [65:0] b);
    for (int k = 0; k < 66; k++) begin
      refq[tail % 8192] = b[k];
      tail++;
    end
  endtask

  // One clock: check outputs at the negedge against the bit-queue model, then drive.
  task automatic drive_cycle(input logic v, input logic [1:0] h, input logic [63:0] d,
                             input string vtag, input string wtag, input int stop_words,
                             output bit took);
    int fill_ref;
    bit ov_exp;
    bit rdy_exp;
    logic [31:0] w;
    logic vv;
    @(negedge clk);
    vv = v;
    fill_ref = tail - head;
    ov_exp = (fill_ref >= 32);
    chk(out_valid === ov_exp, vtag, 64'(out_valid), 64'(ov_exp));
    if (ov_exp) begin
      for (int k = 0; k < 32; k++) w[k] = refq[(head + k) % 8192];
      head += 32;
      words++;
      chk(out_word === w, wtag, 64'(out_word), 64'(w));
    end
    rdy_exp = ((fill_ref - (ov_exp ? 32 : 0)) < 32);
    chk(in_ready === rdy_exp, "R4", 64'(in_ready), 64'(rdy_exp));
    if (stop_words > 0 && words >= stop_words) vv = 1'b0;
    in_valid   = vv;
    in_hdr     = h;
    in_payload = d;
    took = vv && in_ready;
    if (took) begin
      push_blk({d, h});
      chk((tail - head) <= 97, "R3", 64'(tail - head), 64'd97);
    end
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    head = 0;
    tail = 0;
    words = 0;
    repeat (n) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R1", 64'(out_valid), 64'd0);
      chk(in_ready === 1'b1, "R1", 64'(in_ready), 64'd1);
    end
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit took;
    int bi;
    logic [63:0] pay;

    // R1: reset state, and idle until the first block.
    do_reset(3);
    for (int c = 0; c < 4; c++) drive_cycle(1'b0, 2'b00, 64'h0, "R1", "R2", 0, took);

    // Table walk: two full ratio periods of an always-valid source (R2, R4, R5, R6).
    bi = 0;
    for (int c = 0; c < 67; c++) begin
      drive_cycle(1'b1, VH[bi % 16], VD[bi % 16] ^ 64'(bi), "R5", "R2", 66, took);
      if (c < 66) chk(in_ready === EXP_READY[c % 33], "R6", 64'(in_ready), 64'(EXP_READY[c % 33]));
      if (took) bi++;
    end
    // R9: after 66 words the buffer is empty, so nothing is valid.
    drive_cycle(1'b0, 2'b00, 64'h0, "R9", "R2", 0, took);
    chk(out_valid === 1'b0, "R9", 64'(out_valid), 64'd0);
    chk(in_ready === 1'b1, "R9", 64'(in_ready), 64'd1);

    // R8: a source with gaps; leftover bits must lead when it resumes.
    for (int c = 0; c < 70; c++) begin
      drive_cycle((c % 7) < 2, VH[c % 16], ~VD[(c + 5) % 16], "R8", "R8", 0, took);
    end

    // R7: data changes every cycle, including stalled cycles.
    for (int c = 0; c < 60; c++) begin
      pay = {32'(c) * 32'h9E37_79B9, ~32'(c)};
      drive_cycle(1'b1, 2'(c), pay, "R7", "R7", 0, took);
    end

    // R1: reset in mid-stream drops buffered bits; R2 directed first word.
    do_reset(1);
    drive_cycle(1'b0, 2'b00, 64'h0, "R1", "R1", 0, took);
    pay = 64'hC3A5_0F1E_7788_9AB6;
    drive_cycle(1'b1, 2'b01, pay, "R1", "R1", 0, took);
    chk(took === 1'b1, "R1", 64'(took), 64'd1);
    drive_cycle(1'b0, 2'b00, 64'h0, "R5", "R2", 0, took);
    chk(out_word === {pay[29:0], 2'b01}, "R2", 64'(out_word), 64'({pay[29:0], 2'b01}));
    for (int c = 0; c < 4; c++) drive_cycle(1'b0, 2'b00, 64'h0, "R8", "R2", 0, took);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule